// File: doc/BRIEF.md
# Switching Clock Source Selector

This block decides which timing source paces a switching power controller. An internal free-running oscillator delivers a one-cycle tick on the system clock once per internal period. An external synchronisation input arrives asynchronously. The block turns the chosen source into one enable pulse per switching cycle. It also reports which source is currently in charge.

The external input is brought into the system clock domain by a flop synchronizer, and its rising edges are detected there. The first accepted external edge takes over at once. A watchdog counts internal ticks with no external edge in between. Once it reaches its limit, the internal oscillator resumes. The tick that hits the limit becomes the next cycle boundary, so switching goes on without a missing cycle. While soft-start is active, external edges are disregarded.

All pins are plain control and status signals. No stream carries data here, so there is no valid/ready handshake and no back-pressure.

Top module: `clk_sync_select`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after it rises with no stimulus, `clk_en` is 0 and `ext_active` is 0 (internal source).
- R2: With the internal source selected, every cycle with `int_tick` high gives exactly one `clk_en` pulse in the following cycle.
- R3: A rising edge on `sync_in` that is accepted while the internal source is selected switches to the external source. `ext_active` goes to 1 and `clk_en` pulses in the same cycle, three clock edges after `sync_in` changes (two synchronizer stages plus the output register). A level that stays high gives no further pulses.
- R4: While `ss_active` is 1, rising edges of `sync_in` cause no pulse and no switch.
- R5: With the external source selected, each accepted `sync_in` rising edge gives exactly one `clk_en` pulse, and `int_tick` by itself gives none until the timeout is reached.
- R6: With the external source selected, the block falls back on the `TIMEOUT_TICKS`-th (default 2) internal tick that arrives with no accepted edge. That tick produces a `clk_en` pulse in the same cycle that `ext_active` drops to 0.
- R7: Every accepted external edge restarts the tick count from zero. A tick counted before the edge does not count toward the timeout.
- R8: When an accepted edge and an `int_tick` fall in the same cycle, only one single-cycle `clk_en` pulse results. The edge decides the source, so the block stays external, or switches to external, even when that tick would have been the terminal one.
- R9: If `ss_active` rises while the external source is selected, later edges are ignored, and the block falls back through the timeout of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | One-cycle pulse per internal oscillator period |
| sync_in | input | 1 | Asynchronous external synchronisation clock |
| ss_active | input | 1 | High while soft-start is running; external edges are ignored |
| clk_en | output | 1 | One-cycle enable marking the start of each switching cycle |
| ext_active | output | 1 | 1 when the external source is selected |

## Verification
Two events can land in the same cycle. One is an accepted external edge, and the other is an internal tick, which may be the tick that ends the timeout. The bench provokes this by raising `sync_in` two clock edges before it drives `int_tick`, so the detected edge and the tick reach the selector at the same edge. The result passes only if exactly one `clk_en` pulse appears, `ext_active` stays high, and a fresh count of two ticks is then needed before the block falls back.

// File: rtl/clk_sync_select_pkg.sv
package clk_sync_select_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level; chain[STAGES] is its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tick_timeout.sv
module tick_timeout #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (restart)                      cnt <= '0;
    else if (tick && cnt != CW'(LIMIT))    cnt <= cnt + 1'b1;
  end

  assign expire = tick && !restart && (cnt == CW'(LIMIT - 1));

  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: rtl/src_selector.sv
module src_selector
  import clk_sync_select_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_ok,
  input  logic tick,
  input  logic expire,
  output logic clk_en,
  output logic ext_active
);
  clk_src_e src_q, src_d;
  logic     pulse_d;

  always_comb begin
    src_d   = src_q;
    pulse_d = 1'b0;
    if (edge_ok) begin
      src_d   = SRC_EXT;
      pulse_d = 1'b1;
    end else if (src_q == SRC_EXT) begin
      if (expire) begin
        src_d   = SRC_INT;
        pulse_d = 1'b1;
      end
    end else begin
      pulse_d = tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_INT;
      clk_en <= 1'b0;
    end else begin
      src_q  <= src_d;
      clk_en <= pulse_d;
    end
  end

  assign ext_active = (src_q == SRC_EXT);

  assert_entry_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_active) |-> clk_en);
  assert_exit_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_active) |-> clk_en);
  assert_reset_internal_R1: assert property (@(posedge clk)
    !rst_n |=> !ext_active && !clk_en);
endmodule

// File: rtl/clk_sync_select.sv
module clk_sync_select #(
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_tick,
  input  logic sync_in,
  input  logic ss_active,
  output logic clk_en,
  output logic ext_active
);
  logic sync_rise, edge_ok, expire;

  sync_rise_det #(.STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .async_in(sync_in), .rise(sync_rise)
  );

  assign edge_ok = sync_rise & ~ss_active;

  tick_timeout #(.LIMIT(TIMEOUT_TICKS)) u_to (
    .clk(clk), .rst_n(rst_n), .restart(edge_ok), .tick(int_tick), .expire(expire)
  );

  src_selector u_sel (
    .clk(clk), .rst_n(rst_n), .edge_ok(edge_ok), .tick(int_tick),
    .expire(expire), .clk_en(clk_en), .ext_active(ext_active)
  );

  assert_softstart_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_active) |-> !$past(ss_active));
endmodule

// File: tb/clk_sync_select_tb_top.sv
module clk_sync_select_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, int_tick = 1'b0, sync_in = 1'b0, ss_active = 1'b0;
  logic clk_en, ext_active;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  clk_sync_select dut_i (.clk(clk), .rst_n(rst_n), .int_tick(int_tick),
    .sync_in(sync_in), .ss_active(ss_active), .clk_en(clk_en), .ext_active(ext_active));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic en_exp, logic ext_exp);
    n_run++;
    if (clk_en !== en_exp || ext_active !== ext_exp) begin
      n_fail++;
      $display("FAIL %s: clk_en=%b ext_active=%b expected clk_en=%b ext_active=%b",
               req, clk_en, ext_active, en_exp, ext_exp);
    end
  endtask

  task automatic tick();
    int_tick = 1'b1; step(); int_tick = 1'b0;
  endtask

  task automatic t_reset();
    step(3); chk("R1", 0, 0);
    rst_n = 1'b1; step(); chk("R1", 0, 0);
  endtask

  task automatic t_internal();
    tick(); chk("R2", 1, 0);
    step(); chk("R2", 0, 0);
  endtask

  task automatic t_ss_ignore();
    ss_active = 1'b1; sync_in = 1'b1;
    for (int i = 0; i < 4; i++) begin step(); chk("R4", 0, 0); end
    sync_in = 1'b0; step(3); ss_active = 1'b0;
  endtask

  task automatic t_switch();
    sync_in = 1'b1; step(2); chk("R3", 0, 0);
    step(); chk("R3", 1, 1);
    step(); chk("R3", 0, 1);
    step(3); chk("R3", 0, 1);
    sync_in = 1'b0; step(3);
  endtask

  task automatic t_ext_timeout();
    tick(); chk("R5", 0, 1);
    sync_in = 1'b1; step(3); chk("R5", 1, 1);
    tick(); chk("R7", 0, 1);
    tick(); chk("R6", 1, 0);
    tick(); chk("R2", 1, 0);
    sync_in = 1'b0; step(3);
  endtask

  task automatic t_merge();
    sync_in = 1'b1; step(2);
    int_tick = 1'b1; step(); int_tick = 1'b0;
    chk("R8", 1, 1);
    step(); chk("R8", 0, 1);
  endtask

  task automatic t_edge_at_timeout();
    tick(); chk("R5", 0, 1);
    sync_in = 1'b0; step(3);
    sync_in = 1'b1; step(2);
    int_tick = 1'b1; step(); int_tick = 1'b0;
    chk("R8", 1, 1);
    step(); chk("R8", 0, 1);
    tick(); chk("R7", 0, 1);
    tick(); chk("R6", 1, 0);
    sync_in = 1'b0; step(3);
  endtask

  task automatic t_ss_in_ext();
    sync_in = 1'b1; step(3); chk("R9", 1, 1);
    ss_active = 1'b1;
    sync_in = 1'b0; step(3);
    sync_in = 1'b1; step(3); chk("R9", 0, 1);
    tick(); chk("R9", 0, 1);
    tick(); chk("R9", 1, 0);
    ss_active = 1'b0; sync_in = 1'b0; step(3);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_ss_ignore();
    t_switch();
    t_ext_timeout();
    t_merge();
    t_edge_at_timeout();
    t_ss_in_ext();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule